// File: doc/BRIEF.md
# Multi-bank flash command decoder

This block interprets host write cycles aimed at a banked 16-bit NOR-style flash model and keeps a separate mode for every bank: plain array read, query-table read, identification read, unlock bypass, or a stuck error state. Each write names a bank and a word offset inside it. Only the low data byte is matched against command codes. A small register array, loaded with a computed pattern on reset, stands in for the flash cells and can be written only through the program step of unlock bypass.

Reads name a bank and an offset. The data word is chosen by that bank's current mode: array contents, a constant query table, identification and sector-lock words, or an all-ones invalid word. While one bank serves the query table or identification words, the other banks still serve array reads but refuse every write.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A synchronous active-high `rst` puts every bank in array mode with no sequence in progress, loads word o of bank b with {b[3:0], 4'hA, o[3:0], 4'(15-o)}, and clears `rdata` to 0x0000.
- R2: A write of 0x98 to offset 0x555 of a bank that is in array mode with no sequence in progress puts that bank in query mode.
- R3: In query mode, reads at offsets 0x10 to 0x4F return table entry i = offset-0x10, which is 0x0051, 0x0052, 0x0059 for i = 0, 1, 2 and {8'h00, (3+5*i) mod 256} otherwise. All other offsets of that bank return 0xFFFF.
- R4: While any bank is in query or identification mode, reads of other banks return array data and writes to other banks change nothing.
- R5: A write of 0xF0 to any offset of a bank in query, identification or error mode returns it to array mode. In array mode a lone 0xF0 changes nothing.
- R6: Data bits 15 to 8 are ignored when command codes are matched.
- R7: In array mode the prefix is 0xAA at 0x555 then 0x55 at 0x2AA. Any other second write, or any third write other than those of R8 and R10, puts the bank in error mode. In error mode every read returns 0xFFFF and only 0xF0 leaves it.
- R8: Prefix then 0x90 at 0x555 enters identification mode. Reads with offset bits 7:0 equal to 0x00 return MFR_ID (default 0x0001), 0x01 returns DEV_ID (default 0x223C), and other values except 0x02 return 0xFFFF.
- R9: In identification mode, reads with offset bits 7:0 equal to 0x02 return 0x0001 when the sector is locked and 0x0000 otherwise. The sector is offset bits 10:9, and its lock bit is LOCK_MASK[bank*4 + sector]. The default locks bank 0 sector 0, bank 1 sector 1 and bank 2 sector 2.
- R10: Prefix then 0x20 at 0x555 enters unlock bypass. There 0xF0 has no effect. A write of 0x90 followed by a write of 0x00, at any offsets, returns the bank to array mode.
- R11: In unlock bypass, a write of 0xA0 followed by another write stores the full 16-bit data word at array word offset[3:0]. Bypass reads return array data. Array-mode writes never alter the array.
- R12: `rdata` is registered. It takes the selected word on the clock edge where `rd_en` is high and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write cycle strobe |
| rd_en | input | 1 | Host read cycle strobe |
| bank | input | 2 | Bank selected by the cycle |
| addr | input | 11 | Word offset within the bank |
| wdata | input | 16 | Write data / command word |
| rdata | output | 16 | Registered read data |

## Verification
The hardest situation to reach is a write that is refused because a different bank is in query or identification mode. A refused write changes no output directly. The stimulus therefore sends the first word of a prefix to a blocked bank, releases the blocking bank, and then sends only the remaining prefix words. An identification read that comes back as array data shows that the first word was dropped. The same approach shows that 0xF0 is ignored in unlock bypass: a program step issued after it must land in the array.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {M_ARRAY, M_CFI, M_AUTOSEL, M_BYPASS, M_ERROR} mode_t;
  typedef enum logic [2:0] {S_IDLE, S_UNL1, S_UNL2, S_PGM, S_BRST} step_t;

  localparam logic [7:0] C_CFI   = 8'h98;
  localparam logic [7:0] C_UNLA  = 8'hAA;
  localparam logic [7:0] C_UNLB  = 8'h55;
  localparam logic [7:0] C_AUTO  = 8'h90;
  localparam logic [7:0] C_BYP   = 8'h20;
  localparam logic [7:0] C_RESET = 8'hF0;
  localparam logic [7:0] C_PGM   = 8'hA0;
  localparam logic [7:0] C_BEXIT = 8'h00;

  localparam int unsigned ADR_UNL1 = 32'h555;
  localparam int unsigned ADR_UNL2 = 32'h2AA;
  localparam int unsigned CFI_LO   = 32'h10;
  localparam int unsigned CFI_HI   = 32'h4F;
  localparam logic [15:0] INVALID  = 16'hFFFF;

  // query table word for entry idx (0 = first word of the window)
  function automatic logic [15:0] cfi_word(input int unsigned idx);
    case (idx)
      0: return 16'h0051;
      1: return 16'h0052;
      2: return 16'h0059;
      default: return {8'h00, 8'(idx * 5 + 3)};
    endcase
  endfunction

  // power-up pattern of the array word at bank b, word o
  function automatic logic [15:0] init_word(input int unsigned b, input int unsigned o);
    return {4'(b), 4'hA, 4'(o), 4'(15 - (o % 16))};
  endfunction

endpackage

// File: rtl/flash_bank_fsm.sv
module flash_bank_fsm
  import flash_cmd_pkg::*;
#(
  parameter int OFS_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic [OFS_W-1:0] addr,
  input  logic [7:0]       cmd,
  output mode_t            mode,
  output step_t            step,
  output logic             pgm_fire
);

  logic  at_unl1, at_unl2, cfi_hit;
  mode_t mode_n;
  step_t step_n;

  assign at_unl1 = (32'(addr) == ADR_UNL1);
  assign at_unl2 = (32'(addr) == ADR_UNL2);
  assign cfi_hit = wr_hit && (mode == M_ARRAY) && (step == S_IDLE) && at_unl1 && (cmd == C_CFI);

  always_comb begin
    mode_n   = mode;
    step_n   = step;
    pgm_fire = 1'b0;
    if (wr_hit) begin
      case (mode)
        M_ARRAY: begin
          case (step)
            S_IDLE: begin
              if (cfi_hit) mode_n = M_CFI;
              else if (at_unl1 && cmd == C_UNLA) step_n = S_UNL1;
            end
            S_UNL1: begin
              if (at_unl2 && cmd == C_UNLB) step_n = S_UNL2;
              else begin
                mode_n = M_ERROR;
                step_n = S_IDLE;
              end
            end
            S_UNL2: begin
              step_n = S_IDLE;
              if (at_unl1 && cmd == C_AUTO) mode_n = M_AUTOSEL;
              else if (at_unl1 && cmd == C_BYP) mode_n = M_BYPASS;
              else mode_n = M_ERROR;
            end
            default: step_n = S_IDLE;
          endcase
        end
        M_CFI, M_AUTOSEL, M_ERROR: begin
          if (cmd == C_RESET) begin
            mode_n = M_ARRAY;
            step_n = S_IDLE;
          end
        end
        M_BYPASS: begin
          case (step)
            S_IDLE: begin
              if (cmd == C_PGM) step_n = S_PGM;
              else if (cmd == C_AUTO) step_n = S_BRST;
            end
            S_PGM: begin
              pgm_fire = 1'b1;
              step_n   = S_IDLE;
            end
            S_BRST: begin
              step_n = S_IDLE;
              if (cmd == C_BEXIT) mode_n = M_ARRAY;
            end
            default: step_n = S_IDLE;
          endcase
        end
        default: begin
          mode_n = M_ARRAY;
          step_n = S_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= M_ARRAY;
      step <= S_IDLE;
    end else begin
      mode <= mode_n;
      step <= step_n;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mode == M_ARRAY && step == S_IDLE));

  // R2
  cfi_entry_chk: assert property (@(posedge clk) disable iff (rst)
    cfi_hit |=> (mode == M_CFI));

  // R4
  refused_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> ($stable(mode) && $stable(step)));

  // R7
  error_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && mode == M_ERROR && cmd != C_RESET) |=> (mode == M_ERROR));

  // R10
  bypass_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && mode == M_BYPASS && cmd == C_RESET) |=> (mode == M_BYPASS));

endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
  import flash_cmd_pkg::*;
#(
  parameter int          OFS_W  = 11,
  parameter logic [15:0] MFR_ID = 16'h0001,
  parameter logic [15:0] DEV_ID = 16'h223C
) (
  input  mode_t            mode,
  input  logic [OFS_W-1:0] addr,
  input  logic [15:0]      arr_word,
  input  logic             locked,
  output logic [15:0]      data
);

  logic in_window;
  assign in_window = (32'(addr) >= CFI_LO) && (32'(addr) <= CFI_HI);

  always_comb begin
    case (mode)
      M_ARRAY, M_BYPASS: data = arr_word;
      M_CFI:             data = in_window ? cfi_word(32'(addr) - CFI_LO) : INVALID;
      M_AUTOSEL: begin
        case (addr[7:0])
          8'h00:   data = MFR_ID;
          8'h01:   data = DEV_ID;
          8'h02:   data = {15'b0, locked};
          default: data = INVALID;
        endcase
      end
      default:           data = INVALID;
    endcase
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int          NUM_BANKS = 4,
  parameter int          OFS_W     = 11,
  parameter int          ARRAY_AW  = 4,
  parameter int          SECT_W    = 2,
  parameter logic [15:0] MFR_ID    = 16'h0001,
  parameter logic [15:0] DEV_ID    = 16'h223C,
  parameter logic [NUM_BANKS*(2**SECT_W)-1:0] LOCK_MASK = 16'h0421
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       wr_en,
  input  logic                                       rd_en,
  input  logic [((NUM_BANKS>1)?$clog2(NUM_BANKS):1)-1:0] bank,
  input  logic [OFS_W-1:0]                           addr,
  input  logic [15:0]                                wdata,
  output logic [15:0]                                rdata
);

  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int WORDS  = 1 << ARRAY_AW;
  localparam int SECTS  = 1 << SECT_W;
  localparam int DEPTH  = NUM_BANKS * WORDS;

  mode_t                mode_vec [NUM_BANKS];
  step_t                step_vec [NUM_BANKS];
  logic [NUM_BANKS-1:0] busy, wr_hit, pgm_vec, bank_sel;
  logic                 blocked, store_en, locked;
  logic [15:0]          mem [DEPTH];
  logic [15:0]          arr_word, mux_data;
  int unsigned          word_idx, lock_idx;

  assign bank_sel = NUM_BANKS'(1) << bank;
  assign blocked  = |(busy & ~bank_sel);
  assign wr_hit   = (wr_en && !blocked) ? bank_sel : '0;
  assign store_en = |pgm_vec;
  assign word_idx = 32'(bank) * WORDS + 32'(addr[ARRAY_AW-1:0]);
  assign lock_idx = 32'(bank) * SECTS + 32'(addr[OFS_W-1 -: SECT_W]);
  assign arr_word = mem[word_idx];
  assign locked   = LOCK_MASK[lock_idx];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign busy[b] = (mode_vec[b] == M_CFI) || (mode_vec[b] == M_AUTOSEL);
    flash_bank_fsm #(.OFS_W(OFS_W)) u_fsm (
      .clk      (clk),
      .rst      (rst),
      .wr_hit   (wr_hit[b]),
      .addr     (addr),
      .cmd      (wdata[7:0]),
      .mode     (mode_vec[b]),
      .step     (step_vec[b]),
      .pgm_fire (pgm_vec[b])
    );
  end

  flash_read_mux #(.OFS_W(OFS_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_mux (
    .mode     (mode_vec[bank]),
    .addr     (addr),
    .arr_word (arr_word),
    .locked   (locked),
    .data     (mux_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= init_word(i / WORDS, i % WORDS);
    end else if (store_en) begin
      mem[word_idx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= 16'h0000;
    else if (rd_en) rdata <= mux_data;
  end

  // R3
  cfi_outside_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && mode_vec[bank] == M_CFI && (32'(addr) < CFI_LO || 32'(addr) > CFI_HI))
    |=> (rdata == INVALID));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  // R4
  refuse_store_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && blocked) |-> !store_en);

endmodule

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  bank = '0;
  logic [10:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  int tests = 0;
  int fails = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  flash_cmd_decoder uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .bank(bank), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  function automatic logic [15:0] pat(int b, int o);
    int w = o & 15;
    return 16'((b << 12) | 16'h0A00 | (w << 4) | (15 - w));
  endfunction

  function automatic logic [15:0] tbl(int ofs);
    int i = ofs - 16;
    if (i == 0) return 16'h0051;
    if (i == 1) return 16'h0052;
    if (i == 2) return 16'h0059;
    return 16'((3 + 5 * i) % 256);
  endfunction

  task automatic chk(logic [15:0] act, logic [15:0] exp, string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(int b, int a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b0; bank = 2'(b); addr = 11'(a); wdata = d;
  endtask

  task automatic rd(int b, int a, logic [15:0] e, string tag);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1; bank = 2'(b); addr = 11'(a);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0; addr = 11'h005;
    end
  endtask

  task automatic prefix(int b, logic [15:0] third);
    wr(b, 'h555, 16'h00AA);
    wr(b, 'h2AA, 16'h0055);
    wr(b, 'h555, third);
  endtask

  // monitor: pops the scoreboard after each read cycle
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en) begin
        @(negedge clk);
        #1;
        if (exp_q.size() != 0) chk(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rdata, 16'h0000, "R1 rdata after reset");
    rd(0, 3, pat(0, 3), "R1 array bank0");
    rd(2, 'h0F, pat(2, 15), "R1 array bank2");

    // R2 / R6: upper byte set on the query command
    wr(1, 'h555, 16'h1298);
    rd(1, 'h10, tbl('h10), "R2 query first word");
    rd(1, 'h12, tbl('h12), "R3 query third word");
    rd(1, 'h4F, tbl('h4F), "R3 query last word");
    rd(1, 'h0F, 16'hFFFF, "R3 below window");
    rd(1, 'h50, 16'hFFFF, "R3 above window");
    rd(0, 5, pat(0, 5), "R4 other bank reads array");
    wr(0, 'h555, 16'h00AA);            // refused
    wr(1, 'h123, 16'h00F0);            // R5 exit
    rd(1, 'h10, pat(1, 0), "R5 exit query");
    wr(0, 'h2AA, 16'h0055);
    wr(0, 'h555, 16'h0090);
    rd(0, 1, pat(0, 1), "R4 refused write had no effect");
    wr(2, 0, 16'h00F0);
    rd(2, 1, pat(2, 1), "R5 reset in array mode");

    // R8 / R6 / R9
    wr(2, 'h555, 16'hFFAA);
    wr(2, 'h2AA, 16'h3355);
    wr(2, 'h555, 16'h7790);
    rd(2, 'h000, 16'h0001, "R8 manufacturer word");
    rd(2, 'h001, 16'h223C, "R8 device word");
    rd(2, 'h003, 16'hFFFF, "R8 undefined id offset");
    rd(2, 'h402, 16'h0001, "R9 locked sector");
    rd(2, 'h202, 16'h0000, "R9 unlocked sector");
    rd(3, 7, pat(3, 7), "R4 array read during id mode");
    wr(3, 'h555, 16'h0098);            // refused
    wr(2, 0, 16'h00F0);
    rd(3, 'h10, pat(3, 0), "R4 refused query entry");
    rd(2, 'h001, pat(2, 1), "R5 exit id mode");

    // R7 error by data and by address
    wr(3, 'h555, 16'h00AA);
    wr(3, 'h2AA, 16'h0056);
    rd(3, 5, 16'hFFFF, "R7 error read");
    wr(3, 'h555, 16'h0090);
    rd(3, 5, 16'hFFFF, "R7 error persists");
    wr(3, 0, 16'h00F0);
    rd(3, 5, pat(3, 5), "R7 recovered");
    wr(3, 'h555, 16'h00AA);
    wr(3, 'h2AB, 16'h0055);
    rd(3, 6, 16'hFFFF, "R7 wrong address");
    wr(3, 0, 16'h00F0);
    prefix(3, 16'h0011);
    rd(3, 6, 16'hFFFF, "R7 wrong third command");
    wr(3, 0, 16'h00F0);

    // R10 / R11 bypass
    prefix(0, 16'h0020);
    rd(0, 4, pat(0, 4), "R11 bypass array read");
    wr(0, 0, 16'h00F0);
    wr(0, 0, 16'h00A0);
    wr(0, 4, 16'hBEEF);
    rd(0, 4, 16'hBEEF, "R10 F0 ignored, R11 program");
    rd(0, 5, pat(0, 5), "R11 neighbour untouched");
    wr(0, 0, 16'h0090);
    wr(0, 0, 16'h0000);
    wr(0, 0, 16'h00A0);
    wr(0, 4, 16'h1111);
    rd(0, 4, 16'hBEEF, "R11 no program in array mode");
    wr(0, 'h555, 16'h0098);
    rd(0, 'h11, tbl('h11), "R10 bypass exit reached array mode");
    wr(0, 0, 16'h00F0);

    // R12 hold
    rd(0, 4, 16'hBEEF, "R12 read");
    idle(3);
    chk(rdata, 16'hBEEF, "R12 hold while rd_en low");

    idle(2);
    wait (exp_q.size() == 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule